// File: doc/BRIEF.md
# IrDA SIR Pulse Codec

This block sits between the serial data pins of a UART and an infrared transceiver. On the transmit side it turns every zero bit of the UART's output into a short active-high light pulse and leaves every one bit and the idle line dark. On the receive side it does the inverse: a pulse seen on the infrared input marks the current bit period as a zero, and a bit period without a pulse is a one. The recovered bit is presented to the UART one bit period later, aligned to clean bit boundaries.

Two configuration bits live in an 8-bit register. One turns the pulse encoding on; when it is off, both directions are plain wires and the block behaves like an ordinary UART line. The other picks the pulse width. It is either three sixteenths of the bit time, taken from the UART's 16x baud enable, or a fixed absolute width counted in system clocks. That count is the rounded-up product of the clock frequency and the pulse duration, computed when the block is elaborated. The register only accepts a write while the UART transmitter and receiver are both disabled.

The bit phase of the transmit side is taken from the data edges of the UART's serial output. The receive side re-locks its bit phase on the first valid pulse after a stretch of dark bit periods.

Top module: `irsir_codec`

## Requirements
- R1: After reset the configuration reads as 0x00, so encoding is off, the 3/16 width is selected and both directions pass straight through.
- R2: With encoding off (config bit 0 = 0), `ir_tx` equals `uart_txd` and `uart_rxd` equals `ir_rx` in the same cycle.
- R3: With encoding on and config bit 1 = 0, each zero bit produces one pulse on `ir_tx`. It rises on the seventh 16x tick after the bit's start edge and lasts exactly three tick periods.
- R4: With encoding on, one bits and the idle line leave `ir_tx` low.
- R5: With encoding on and config bit 1 = 1, each zero bit produces one pulse. It starts on the same tick as in R3 and lasts exactly ceil(CLK_HZ × PULSE_NS / 1e9) system clocks, whatever the bit rate.
- R6: With encoding on, a high level on `ir_rx` held for at least two clocks marks the current bit period as zero. `uart_rxd` gives each bit's value during the following bit period. After IDLE_BITS dark bit periods, the first such pulse re-locks the bit phase.
- R7: A high level on `ir_rx` that lasts a single clock is ignored, and `uart_rxd` stays 1.
- R8: A configuration write made while `tx_en` or `rx_en` is high leaves the configuration unchanged.
- R9: Configuration bits 7..2 are reserved. Writing them has no effect and they read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud16_en | input | 1 | One-cycle enable at 16 times the bit rate |
| tx_en | input | 1 | UART transmitter enabled (locks configuration) |
| rx_en | input | 1 | UART receiver enabled (locks configuration) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data (bit 0 encode on, bit 1 fixed width) |
| cfg_rdata | output | 8 | Current configuration, reserved bits zero |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| uart_rxd | output | 1 | Recovered serial data to the UART receiver |
| ir_tx | output | 1 | Drive to the infrared emitter |
| ir_rx | input | 1 | Signal from the infrared detector, active high |

## Verification
The hardest state to reach is a receiver that has gone dark and must re-lock onto a pulse whose phase bears no relation to its old bit boundaries. Before such a frame, the bench idles the line for a clock count that is not a whole number of bit periods, so the receiver's free-running phase ends up misaligned. It then checks that every recovered bit of the next frame is correct. Glitch rejection is just as hard to hit through the normal loopback, because the encoder never emits a one-clock pulse. For that case the bench cuts the loopback and drives the infrared input directly with one-clock and three-clock pulses.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  localparam int unsigned SUBTICKS    = 16;
  localparam int unsigned PH_W        = $clog2(SUBTICKS);
  localparam int unsigned PULSE_FIRST = 7;
  localparam int unsigned PULSE_LAST  = 9;
  localparam int unsigned ALIGN_PH    = 8;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned MOD_BIT     = 0;
  localparam int unsigned LPM_BIT     = 1;

  typedef struct packed {
    logic lpm;
    logic mod;
  } irsir_mode_t;
endpackage

// File: rtl/irsir_cfg.sv
module irsir_cfg
  import irsir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             tx_en,
  input  logic             rx_en,
  output irsir_mode_t      mode,
  output logic [REG_W-1:0] rdata
);
  localparam logic [REG_W-1:0] KEEP_MASK = REG_W'((1 << MOD_BIT) | (1 << LPM_BIT));

  irsir_mode_t mode_q, mode_d;
  logic        wr_ok;
  logic        unused_rsvd;

  assign wr_ok       = wr && !tx_en && !rx_en;
  assign unused_rsvd = ^(wdata & ~KEEP_MASK);

  always_comb begin
    mode_d = mode_q;
    if (wr_ok) begin
      mode_d.mod = wdata[MOD_BIT];
      mode_d.lpm = wdata[LPM_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  always_comb begin
    rdata          = '0;
    rdata[MOD_BIT] = mode_q.mod;
    rdata[LPM_BIT] = mode_q.lpm;
  end

  assign mode = mode_q;
endmodule

// File: rtl/irsir_enc.sv
module irsir_enc
  import irsir_pkg::*;
#(
  parameter int unsigned FIX_CYC = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        txd,
  input  irsir_mode_t mode,
  output logic        pulse
);
  localparam int unsigned CNT_W = $clog2(FIX_CYC + 1);

  logic             txd_q;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             data_edge, in_win, start;

  assign data_edge = txd ^ txd_q;

  // sub-bit phase: restarts on every data edge, advances on each 16x tick
  always_comb begin
    ph_d = ph_q;
    if (data_edge)
      ph_d = '0;
    else if (tick)
      ph_d = (ph_q == PH_W'(SUBTICKS - 1)) ? '0 : ph_q + 1'b1;
  end

  assign in_win = !txd && (ph_d >= PH_W'(PULSE_FIRST)) && (ph_d <= PH_W'(PULSE_LAST));
  assign start  = !txd && (ph_d == PH_W'(PULSE_FIRST)) && (ph_q != PH_W'(PULSE_FIRST));

  // absolute-width counter, loaded when the pulse window opens
  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = CNT_W'(FIX_CYC);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  assign pulse_d = mode.mod && (mode.lpm ? (cnt_d != '0) : in_win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q   <= 1'b1;
      ph_q    <= '0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      txd_q   <= txd;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/irsir_dec.sv
module irsir_dec
  import irsir_pkg::*;
#(
  parameter int unsigned IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic irin,
  output logic rxd
);
  localparam int unsigned EMP_W = $clog2(IDLE_BITS + 1);

  logic             s1_q, s2_q;
  logic [1:0]       run_q, run_d;
  logic [PH_W-1:0]  rph_q, rph_d;
  logic [EMP_W-1:0] emp_q, emp_d;
  logic             seen_q, seen_d;
  logic             idle_q, idle_d;
  logic             rxd_q, rxd_d;
  logic             det, boundary, zero_bit;

  // high-run length, saturating at two
  always_comb begin
    if (!s2_q)               run_d = 2'd0;
    else if (run_q == 2'd2)  run_d = run_q;
    else                     run_d = run_q + 2'd1;
  end

  assign det      = s2_q && (run_q == 2'd1);
  assign boundary = tick && (rph_q == PH_W'(SUBTICKS - 1));
  assign zero_bit = seen_q || det;

  always_comb begin
    rph_d  = rph_q;
    emp_d  = emp_q;
    seen_d = seen_q;
    idle_d = idle_q;
    rxd_d  = rxd_q;
    if (tick)
      rph_d = (rph_q == PH_W'(SUBTICKS - 1)) ? '0 : rph_q + 1'b1;
    if (boundary) begin
      rxd_d  = !zero_bit;
      seen_d = 1'b0;
      if (zero_bit)
        emp_d = '0;
      else if (emp_q != EMP_W'(IDLE_BITS))
        emp_d = emp_q + 1'b1;
      if (!zero_bit && (emp_q >= EMP_W'(IDLE_BITS - 1)))
        idle_d = 1'b1;
    end else if (det) begin
      seen_d = 1'b1;
    end
    if (det && idle_q) begin
      rph_d  = PH_W'(ALIGN_PH);
      seen_d = 1'b1;
      idle_d = 1'b0;
      emp_d  = '0;
      rxd_d  = rxd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      run_q  <= '0;
      rph_q  <= '0;
      emp_q  <= EMP_W'(IDLE_BITS);
      seen_q <= 1'b0;
      idle_q <= 1'b1;
      rxd_q  <= 1'b1;
    end else begin
      s1_q   <= irin;
      s2_q   <= s1_q;
      run_q  <= run_d;
      rph_q  <= rph_d;
      emp_q  <= emp_d;
      seen_q <= seen_d;
      idle_q <= idle_d;
      rxd_q  <= rxd_d;
    end
  end

  assign rxd = rxd_q;
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned PULSE_NS  = 1600,
  parameter int unsigned IDLE_BITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud16_en,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             uart_txd,
  output logic             uart_rxd,
  output logic             ir_tx,
  input  logic             ir_rx
);
  localparam longint unsigned FIX_PROD = 64'(CLK_HZ) * 64'(PULSE_NS);
  localparam longint unsigned FIX_CEIL = (FIX_PROD + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int unsigned     FIX_CYC  = (FIX_CEIL == 0) ? 1 : int'(FIX_CEIL);

  logic        rst_m_q, rst_s_q;
  irsir_mode_t mode;
  logic        enc_pulse, dec_rxd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  irsir_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_s_q),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .tx_en (tx_en),
    .rx_en (rx_en),
    .mode  (mode),
    .rdata (cfg_rdata)
  );

  irsir_enc #(.FIX_CYC(FIX_CYC)) u_enc (
    .clk   (clk),
    .rst_n (rst_s_q),
    .tick  (baud16_en),
    .txd   (uart_txd),
    .mode  (mode),
    .pulse (enc_pulse)
  );

  irsir_dec #(.IDLE_BITS(IDLE_BITS)) u_dec (
    .clk   (clk),
    .rst_n (rst_s_q),
    .tick  (baud16_en),
    .irin  (ir_rx),
    .rxd   (dec_rxd)
  );

  assign ir_tx    = mode.mod ? enc_pulse : uart_txd;
  assign uart_rxd = mode.mod ? dec_rxd   : ir_rx;
endmodule

// File: rtl/irsir_codec_sva.sv
module irsir_codec_sva
  import irsir_pkg::*;
#(
  parameter int unsigned FIX_CYC = 80
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             rx_en,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             uart_txd,
  input logic             uart_rxd,
  input logic             ir_tx,
  input logic             ir_rx
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  run_q <= 0;
    else if (cfg_rdata[MOD_BIT] && cfg_rdata[LPM_BIT] && ir_tx) run_q <= run_q + 1;
    else                                         run_q <= 0;
  end

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[REG_W-1:2] == '0);

  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en || rx_en) |=> $stable(cfg_rdata));

  p_tx_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[MOD_BIT] |-> (ir_tx == uart_txd));

  p_rx_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[MOD_BIT] |-> (uart_rxd == ir_rx));

  p_ones_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[MOD_BIT] && !cfg_rdata[LPM_BIT] && uart_txd)
      |=> (!ir_tx || !cfg_rdata[MOD_BIT] || cfg_rdata[LPM_BIT]));

  p_fixed_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= FIX_CYC);
endmodule

bind irsir_codec irsir_codec_sva #(.FIX_CYC(FIX_CYC)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .cfg_rdata (cfg_rdata),
  .uart_txd  (uart_txd),
  .uart_rxd  (uart_rxd),
  .ir_tx     (ir_tx),
  .ir_rx     (ir_rx)
);

// File: tb/irsir_codec_tb_top.sv
module irsir_codec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int BIT_CLKS   = 16 * DIV;
  localparam int EXP_FIX    = 6;          // ceil(3.75 MHz * 1600 ns)
  localparam int EXP_OFF    = 1 + 7 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, rx_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       uart_txd = 1'b1;
  logic       uart_rxd, ir_tx, ir_rx;
  logic       loop_sel = 1'b0, inj_ir = 1'b0;
  logic [1:0] bcnt;
  logic       baud16_en;

  int nchk = 0, nerr = 0, cyc = 0, start_cyc = 0;
  int rise_cyc = 0, npulse = 0, wmin = 0, wmax = 0, omin = 0, omax = 0;
  bit prev_ir = 1'b0, mon_on = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0; else bcnt <= bcnt + 2'd1;
  assign baud16_en = (bcnt == 2'd0);
  always @(posedge clk) cyc <= cyc + 1;

  assign ir_rx = loop_sel ? ir_tx : inj_ir;

  irsir_codec #(.CLK_HZ(3_750_000), .PULSE_NS(1600), .IDLE_BITS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud16_en(baud16_en), .tx_en(tx_en), .rx_en(rx_en),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .uart_txd(uart_txd), .uart_rxd(uart_rxd), .ir_tx(ir_tx), .ir_rx(ir_rx)
  );

  // pulse monitor on ir_tx
  always @(negedge clk) begin
    if (ir_tx && !prev_ir) rise_cyc = cyc;
    if (!ir_tx && prev_ir && mon_on) begin
      npulse++;
      if (cyc - rise_cyc < wmin) wmin = cyc - rise_cyc;
      if (cyc - rise_cyc > wmax) wmax = cyc - rise_cyc;
      if (rise_cyc - start_cyc < omin) omin = rise_cyc - start_cyc;
      if (rise_cyc - start_cyc > omax) omax = rise_cyc - start_cyc;
    end
    prev_ir = ir_tx;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic clr_stats();
    npulse = 0; wmin = 1 << 20; wmax = 0; omin = 1 << 20; omax = 0;
  endtask

  // sends start, 8 data bits LSB first, stop; rec[k] = uart_rxd sampled mid-bit k+1
  task automatic send_frame(input logic [7:0] d, output logic [9:0] rec);
    logic [9:0] bits;
    bits = {1'b1, d, 1'b0};
    do @(negedge clk); while (bcnt != 2'd0);
    for (int k = 0; k < 10; k++) begin
      uart_txd = bits[k]; start_cyc = cyc;
      repeat (BIT_CLKS/2) @(negedge clk);
      if (k > 0) rec[k-1] = uart_rxd;
      repeat (BIT_CLKS/2) @(negedge clk);
    end
    uart_txd = 1'b1;
    repeat (BIT_CLKS/2) @(negedge clk);
    rec[9] = uart_rxd;
    repeat (BIT_CLKS/2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(cfg_rdata == 8'h00, "R1 cfg after reset", cfg_rdata, 0);
    chk(ir_tx == uart_txd, "R1 ir_tx follows txd", ir_tx, uart_txd);
    chk(uart_rxd == ir_rx, "R1 rxd follows ir_rx", uart_rxd, ir_rx);
  endtask

  task automatic t_cfg_rules();
    tx_en = 1'b1; write_cfg(8'h03); @(negedge clk);
    chk(cfg_rdata == 8'h00, "R8 write with tx_en", cfg_rdata, 0);
    tx_en = 1'b0; rx_en = 1'b1; write_cfg(8'h01); @(negedge clk);
    chk(cfg_rdata == 8'h00, "R8 write with rx_en", cfg_rdata, 0);
    rx_en = 1'b0; write_cfg(8'hFD); @(negedge clk);
    chk(cfg_rdata == 8'h01, "R9 reserved bits read zero", cfg_rdata, 1);
    write_cfg(8'hFC); @(negedge clk);
    chk(cfg_rdata == 8'h00, "R9 reserved write no effect", cfg_rdata, 0);
  endtask

  task automatic t_bypass();
    int bad = 0;
    write_cfg(8'h00); loop_sel = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); uart_txd = i[0]; inj_ir = i[1];
      #1;
      if (ir_tx !== uart_txd || uart_rxd !== inj_ir) bad++;
    end
    chk(bad == 0, "R2 bypass both directions", bad, 0);
    uart_txd = 1'b1; inj_ir = 1'b0;
  endtask

  task automatic t_encode(input logic [7:0] d, input bit lpm, input int gap);
    logic [9:0] rec;
    int zeros, lit, expw;
    string tag;
    tag  = lpm ? "R5" : "R3";
    expw = lpm ? EXP_FIX : 3 * DIV;
    write_cfg({6'b0, lpm, 1'b1}); loop_sel = 1'b1;
    repeat (gap) @(negedge clk);
    zeros = 1;
    for (int i = 0; i < 8; i++) if (!d[i]) zeros++;
    clr_stats(); mon_on = 1'b1;
    send_frame(d, rec);
    mon_on = 1'b0;
    chk(npulse == zeros, {tag, " pulse count (R4 ones dark)"}, npulse, zeros);
    chk(wmin == expw && wmax == expw, {tag, " pulse width"}, wmax, expw);
    chk(omin == EXP_OFF && omax == EXP_OFF, {tag, " pulse start tick"}, omax, EXP_OFF);
    chk(rec[8:1] == d, "R6 recovered data byte", rec[8:1], d);
    chk(rec[0] == 1'b0 && rec[9] == 1'b1, "R6 recovered start/stop", rec, {1'b1, d, 1'b0});
    lit = 0;
    for (int i = 0; i < 3 * BIT_CLKS; i++) begin
      @(negedge clk); if (ir_tx) lit++;
    end
    chk(lit == 0, "R4 idle line dark", lit, 0);
  endtask

  task automatic t_glitch();
    int lows = 0;
    write_cfg(8'h01); loop_sel = 1'b0; inj_ir = 1'b0;
    repeat (12 * BIT_CLKS) @(negedge clk);
    inj_ir = 1'b1; @(negedge clk); inj_ir = 1'b0;
    for (int i = 0; i < 3 * BIT_CLKS; i++) begin
      @(negedge clk); if (!uart_rxd) lows++;
    end
    chk(lows == 0, "R7 one-clock glitch ignored", lows, 0);
    inj_ir = 1'b1; repeat (3) @(negedge clk); inj_ir = 1'b0;
    repeat (57) @(negedge clk);
    chk(uart_rxd == 1'b0, "R6 injected pulse decoded as zero", uart_rxd, 0);
    repeat (30) @(negedge clk);
    chk(uart_rxd == 1'b0, "R6 zero held one bit period", uart_rxd, 0);
    repeat (110) @(negedge clk);
    chk(uart_rxd == 1'b1, "R6 back to one after bit", uart_rxd, 1);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150_000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_cfg_rules();
    t_bypass();
    t_encode(8'hA5, 1'b0, 12 * BIT_CLKS);
    t_encode(8'h00, 1'b0, 11 * BIT_CLKS + 22);
    t_encode(8'h3C, 1'b1, 12 * BIT_CLKS);
    t_encode(8'hFE, 1'b1, 11 * BIT_CLKS + 37);
    t_glitch();
    t_bypass();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule